// File: doc/BRIEF.md
# Communication Controller Shutdown Sequencer

This block takes a time-triggered bus communication controller out of service in an orderly way. On a start request it visits the message buffers one at a time, from index 0 up to a last-used index given on an input. For each buffer it first reads the enable status. A buffer that is already off is passed over. A buffer that is still on gets a disable trigger write, and its status is read again. This repeats until the status reads back as off.

The halt command is sent only after every buffer in range is off. The sequencer then waits for the protocol state input to show the halt code. Two limits stop a run that would otherwise never end. The first is a per-buffer retry limit. The second is a timeout on the halt wait. Either one ends the run with an error code.

The buffer register port and the halt command output are valid/ready request channels. A request stays asserted, with its index and kind unchanged, until the receiver takes it by raising ready in the same cycle. The receiver may hold ready low for any number of cycles to apply back-pressure. A status response comes back on a separate valid strobe at least one cycle after the read request has been accepted. The sequencer always accepts that response, so the response path has no ready signal. Responses that arrive while no read is outstanding are ignored. Start, busy, done and the error outputs are plain level or pulse signals.

Top module: `cc_shutdown_seq`

## Requirements
- R1: While reset is held and afterwards until a start is accepted, busy_o, done_o, err_o, req_valid_o and cmd_valid_o are all 0, and err_code_o is 0.
- R2: start_i is accepted only when busy_o is 0, and busy_o rises in the next cycle. A start while busy_o is 1 has no effect: it produces no extra done pulse and no extra buffer or command traffic.
- R3: Buffer accesses go in non-decreasing index order from 0 to last_idx_i. Every buffer in that range gets a status read (req_wr_o = 0) before any trigger to it. No buffer above last_idx_i is accessed.
- R4: A buffer whose status response reports rsp_en_i = 0 on its first read gets no trigger write (req_wr_o = 1).
- R5: A buffer that reports rsp_en_i = 1 gets one trigger write followed by one status read. This repeats until a read returns 0. A buffer that needs k triggers to clear therefore receives exactly k triggers and k+1 reads.
- R6: If a buffer still reports enabled after RETRY_MAX triggers, the run ends. err_code_o becomes 1 (buffer error), no halt command is sent, and no higher buffer is accessed.
- R7: Exactly one halt command (cmd_valid_o accepted) is sent per successful walk. No buffer request is made while or after it is pending in that run.
- R8: When poc_state_i equals HALT_CODE in the wait phase, the run completes with err_code_o = 0.
- R9: Let D be the number of cycles after the halt command handshake at which poc_state_i first shows HALT_CODE. The run succeeds if D < HALT_TIMEOUT. Otherwise it ends with err_code_o = 2 (halt timeout).
- R10: done_o is a one-cycle pulse issued in the first cycle busy_o is 0. err_o (= err_code_o != 0) and err_code_o keep their value until the next accepted start.
- R11: While req_valid_o or cmd_valid_o is 1 and its ready is 0, the request stays asserted in the next cycle with the same req_idx_o and req_wr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a shutdown run |
| last_idx_i | input | IDX_W | Highest buffer index in use, held stable during a run |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last run ended with an error |
| err_code_o | output | 2 | 0 ok, 1 buffer retry limit, 2 halt timeout |
| req_valid_o | output | 1 | Buffer access request valid |
| req_ready_i | input | 1 | Buffer access request accepted |
| req_wr_o | output | 1 | 1 = disable trigger write, 0 = status read |
| req_idx_o | output | IDX_W | Buffer index of the request |
| rsp_valid_i | input | 1 | Status read response strobe |
| rsp_en_i | input | 1 | Response: 1 = buffer still enabled |
| cmd_valid_o | output | 1 | Halt command valid |
| cmd_ready_i | input | 1 | Halt command accepted |
| poc_state_i | input | STATE_W | Protocol engine state |

## Verification
Two things can happen in the same cycle. A start can arrive in the very cycle that done_o pulses, when busy_o has already dropped. A start can also arrive again in the middle of a run. The bench raises start exactly when it sees the done pulse and expects busy_o to be set one cycle later, with a full second run. In other runs it pulses start mid-walk and expects exactly one done pulse and unchanged trigger counts. Request back-pressure from a periodic ready pattern also coincides with response strobes. Judging uses per-buffer trigger and read counts computed from each buffer's required trigger count and the retry limit.

// File: rtl/cc_sd_pkg.sv
package cc_sd_pkg;
  typedef enum logic [1:0] {SD_OK = 2'd0, SD_ERR_BUF = 2'd1, SD_ERR_HALT = 2'd2} sd_err_e;
  typedef enum logic [1:0] {W_IDLE, W_RDREQ, W_RDWAIT, W_TRREQ} walk_st_e;
  typedef enum logic [1:0] {H_IDLE, H_CMD, H_WAIT} halt_st_e;
  typedef enum logic [1:0] {C_IDLE, C_WALK, C_HALT} ctrl_st_e;
endpackage

// File: rtl/cc_sd_bufwalk.sv
module cc_sd_bufwalk
  import cc_sd_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int RETRY_MAX = 255,
  parameter int RCNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [IDX_W-1:0] last_idx_i,
  output logic             req_valid_o,
  input  logic             req_ready_i,
  output logic             req_wr_o,
  output logic [IDX_W-1:0] req_idx_o,
  input  logic             rsp_valid_i,
  input  logic             rsp_en_i,
  output logic             fin_o,
  output logic             fail_o
);
  localparam logic [RCNT_W-1:0] RLIM = RCNT_W'(RETRY_MAX);

  walk_st_e          st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [RCNT_W-1:0] cnt_q;
  logic              fin_q, fail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      idx_q  <= '0;
      cnt_q  <= '0;
      fin_q  <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      fin_q  <= 1'b0;
      fail_q <= 1'b0;
      unique case (st_q)
        W_IDLE: begin
          if (go_i) begin
            idx_q <= '0;
            cnt_q <= '0;
            st_q  <= W_RDREQ;
          end
        end
        W_RDREQ: begin
          if (req_ready_i) st_q <= W_RDWAIT;
        end
        W_RDWAIT: begin
          if (rsp_valid_i) begin
            if (!rsp_en_i) begin
              if (idx_q == last_idx_i) begin
                fin_q <= 1'b1;
                st_q  <= W_IDLE;
              end else begin
                idx_q <= idx_q + 1'b1;
                cnt_q <= '0;
                st_q  <= W_RDREQ;
              end
            end else if (cnt_q == RLIM) begin
              fin_q  <= 1'b1;
              fail_q <= 1'b1;
              st_q   <= W_IDLE;
            end else begin
              st_q <= W_TRREQ;
            end
          end
        end
        W_TRREQ: begin
          if (req_ready_i) begin
            cnt_q <= cnt_q + 1'b1;
            st_q  <= W_RDREQ;
          end
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

  always_comb begin
    req_valid_o = (st_q == W_RDREQ) || (st_q == W_TRREQ);
    req_wr_o    = (st_q == W_TRREQ);
    req_idx_o   = idx_q;
    fin_o       = fin_q;
    fail_o      = fail_q;
  end
endmodule

// File: rtl/cc_sd_haltwait.sv
module cc_sd_haltwait
  import cc_sd_pkg::*;
#(
  parameter int             STATE_W      = 3,
  parameter logic [STATE_W-1:0] HALT_CODE = '0,
  parameter int             HALT_TIMEOUT = 100000,
  parameter int             TCNT_W       = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_i,
  output logic               cmd_valid_o,
  input  logic               cmd_ready_i,
  input  logic [STATE_W-1:0] poc_state_i,
  output logic               fin_o,
  output logic               fail_o
);
  localparam logic [TCNT_W-1:0] TLAST = TCNT_W'(HALT_TIMEOUT - 1);

  halt_st_e          st_q;
  logic [TCNT_W-1:0] tcnt_q;
  logic              fin_q, fail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= H_IDLE;
      tcnt_q <= '0;
      fin_q  <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      fin_q  <= 1'b0;
      fail_q <= 1'b0;
      unique case (st_q)
        H_IDLE: if (go_i) st_q <= H_CMD;
        H_CMD: begin
          if (cmd_ready_i) begin
            tcnt_q <= '0;
            st_q   <= H_WAIT;
          end
        end
        H_WAIT: begin
          if (poc_state_i == HALT_CODE) begin
            fin_q <= 1'b1;
            st_q  <= H_IDLE;
          end else if (tcnt_q == TLAST) begin
            fin_q  <= 1'b1;
            fail_q <= 1'b1;
            st_q   <= H_IDLE;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        default: st_q <= H_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_valid_o = (st_q == H_CMD);
    fin_o       = fin_q;
    fail_o      = fail_q;
  end
endmodule

// File: rtl/cc_sd_ctrl.sv
module cc_sd_ctrl
  import cc_sd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  output logic       walk_go_o,
  input  logic       walk_fin_i,
  input  logic       walk_fail_i,
  output logic       halt_go_o,
  input  logic       halt_fin_i,
  input  logic       halt_fail_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] err_code_o
);
  ctrl_st_e st_q;
  logic     done_q;
  sd_err_e  err_q;

  always_comb begin
    walk_go_o  = (st_q == C_IDLE) && start_i;
    halt_go_o  = (st_q == C_WALK) && walk_fin_i && !walk_fail_i;
    busy_o     = (st_q != C_IDLE);
    done_o     = done_q;
    err_code_o = err_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= C_IDLE;
      done_q <= 1'b0;
      err_q  <= SD_OK;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        C_IDLE: begin
          if (start_i) begin
            err_q <= SD_OK;
            st_q  <= C_WALK;
          end
        end
        C_WALK: begin
          if (walk_fin_i) begin
            if (walk_fail_i) begin
              err_q  <= SD_ERR_BUF;
              done_q <= 1'b1;
              st_q   <= C_IDLE;
            end else begin
              st_q <= C_HALT;
            end
          end
        end
        C_HALT: begin
          if (halt_fin_i) begin
            err_q  <= halt_fail_i ? SD_ERR_HALT : SD_OK;
            done_q <= 1'b1;
            st_q   <= C_IDLE;
          end
        end
        default: st_q <= C_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cc_shutdown_seq.sv
module cc_shutdown_seq
  import cc_sd_pkg::*;
#(
  parameter int                 NUM_BUF      = 64,
  parameter int                 RETRY_MAX    = 255,
  parameter int                 HALT_TIMEOUT = 100000,
  parameter int                 STATE_W      = 3,
  parameter logic [STATE_W-1:0] HALT_CODE    = '0,
  localparam int                IDX_W        = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [IDX_W-1:0]   last_idx_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic [1:0]         err_code_o,
  output logic               req_valid_o,
  input  logic               req_ready_i,
  output logic               req_wr_o,
  output logic [IDX_W-1:0]   req_idx_o,
  input  logic               rsp_valid_i,
  input  logic               rsp_en_i,
  output logic               cmd_valid_o,
  input  logic               cmd_ready_i,
  input  logic [STATE_W-1:0] poc_state_i
);
  localparam int RCNT_W = $clog2(RETRY_MAX + 1);
  localparam int TCNT_W = (HALT_TIMEOUT > 1) ? $clog2(HALT_TIMEOUT) : 1;

  logic walk_go, walk_fin, walk_fail;
  logic halt_go, halt_fin, halt_fail;

  cc_sd_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .walk_go_o  (walk_go),
    .walk_fin_i (walk_fin),
    .walk_fail_i(walk_fail),
    .halt_go_o  (halt_go),
    .halt_fin_i (halt_fin),
    .halt_fail_i(halt_fail),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_code_o (err_code_o)
  );

  cc_sd_bufwalk #(
    .IDX_W    (IDX_W),
    .RETRY_MAX(RETRY_MAX),
    .RCNT_W   (RCNT_W)
  ) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (walk_go),
    .last_idx_i (last_idx_i),
    .req_valid_o(req_valid_o),
    .req_ready_i(req_ready_i),
    .req_wr_o   (req_wr_o),
    .req_idx_o  (req_idx_o),
    .rsp_valid_i(rsp_valid_i),
    .rsp_en_i   (rsp_en_i),
    .fin_o      (walk_fin),
    .fail_o     (walk_fail)
  );

  cc_sd_haltwait #(
    .STATE_W     (STATE_W),
    .HALT_CODE   (HALT_CODE),
    .HALT_TIMEOUT(HALT_TIMEOUT),
    .TCNT_W      (TCNT_W)
  ) u_halt (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (halt_go),
    .cmd_valid_o(cmd_valid_o),
    .cmd_ready_i(cmd_ready_i),
    .poc_state_i(poc_state_i),
    .fin_o      (halt_fin),
    .fail_o     (halt_fail)
  );

  assign err_o = (err_code_o != 2'd0);
endmodule

// File: rtl/cc_shutdown_seq_chk.sv
module cc_shutdown_seq_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [IDX_W-1:0] last_idx_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             req_valid_o,
  input logic             req_ready_i,
  input logic             req_wr_o,
  input logic [IDX_W-1:0] req_idx_o,
  input logic             cmd_valid_o,
  input logic             cmd_ready_i
);
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!req_valid_o && !cmd_valid_o));
  assert_busy_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
  assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (req_idx_o <= last_idx_i));
  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid_o && req_valid_o));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_idx_o) && $stable(req_wr_o)));
  assert_cmd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=> cmd_valid_o);
endmodule

bind cc_shutdown_seq cc_shutdown_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .last_idx_i (last_idx_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .req_valid_o(req_valid_o),
  .req_ready_i(req_ready_i),
  .req_wr_o   (req_wr_o),
  .req_idx_o  (req_idx_o),
  .cmd_valid_o(cmd_valid_o),
  .cmd_ready_i(cmd_ready_i)
);

// File: tb/cc_shutdown_seq_tb_top.sv
module cc_shutdown_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB   = 4;
  localparam int RMAX = 3;
  localparam int TOUT = 6;
  localparam int IW   = 2;
  localparam logic [2:0] HALT = 3'd5;
  localparam logic [2:0] RUNST = 3'd2;

  logic clk = 0, rst_n = 0, start = 0;
  logic [IW-1:0] last_idx = '0;
  logic busy, done, err;
  logic [1:0] err_code;
  logic req_valid, req_ready, req_wr;
  logic [IW-1:0] req_idx;
  logic rsp_valid, rsp_en;
  logic cmd_valid, cmd_ready;
  logic [2:0] poc;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_shutdown_seq #(
    .NUM_BUF(NB), .RETRY_MAX(RMAX), .HALT_TIMEOUT(TOUT), .STATE_W(3), .HALT_CODE(HALT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .last_idx_i(last_idx),
    .busy_o(busy), .done_o(done), .err_o(err), .err_code_o(err_code),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_wr_o(req_wr), .req_idx_o(req_idx),
    .rsp_valid_i(rsp_valid), .rsp_en_i(rsp_en),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .poc_state_i(poc)
  );

  int n_chk = 0, n_fail = 0;
  int need [NB];
  int trg [NB];
  int rds [NB];
  int halt_cnt, done_cnt, ord_viol, hold_viol, late_req, dly_cfg, dcnt, sc;
  int prev_idx;
  logic model_clr = 0, halt_seen, pv_stall;
  logic [IW-1:0] pv_idx;
  logic pv_wr;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // buffer and protocol engine models plus monitors
  always @(posedge clk) begin
    sc <= sc + 1;
    req_ready <= ((sc % 3) != 1);
    cmd_ready <= ((sc % 4) != 0);
    if (model_clr) begin
      for (int i = 0; i < NB; i++) begin trg[i] <= 0; rds[i] <= 0; end
      halt_cnt <= 0; done_cnt <= 0; ord_viol <= 0; hold_viol <= 0; late_req <= 0;
      prev_idx <= 0; halt_seen <= 0; poc <= RUNST; dcnt <= 0; rsp_valid <= 0; pv_stall <= 0;
    end else begin
      if (done) done_cnt <= done_cnt + 1;
      pv_stall <= req_valid && !req_ready;
      pv_idx <= req_idx;
      pv_wr <= req_wr;
      if (pv_stall && !(req_valid && req_idx == pv_idx && req_wr == pv_wr)) hold_viol <= hold_viol + 1;
      rsp_valid <= 1'b0;
      if (req_valid && req_ready) begin
        if (halt_seen) late_req <= late_req + 1;
        if (int'(req_idx) < prev_idx) ord_viol <= ord_viol + 1;
        prev_idx <= int'(req_idx);
        if (req_wr) begin
          if (rds[req_idx] == 0) ord_viol <= ord_viol + 1;
          trg[req_idx] <= trg[req_idx] + 1;
        end else begin
          rds[req_idx] <= rds[req_idx] + 1;
          rsp_valid <= 1'b1;
          rsp_en <= (trg[req_idx] < need[req_idx]);
        end
      end
      if (cmd_valid && cmd_ready) begin
        halt_cnt <= halt_cnt + 1;
        halt_seen <= 1'b1;
        if (dly_cfg == 0) poc <= HALT; else dcnt <= dly_cfg;
      end else if (dcnt > 0) begin
        dcnt <= dcnt - 1;
        if (dcnt == 1) poc <= HALT;
      end
    end
  end

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (done) begin ok = 1; return; end
    end
    chk("watchdog", 0, 1);
  endtask

  task automatic prep(int lst, int dly);
    @(negedge clk);
    last_idx = IW'(lst);
    dly_cfg = dly;
    model_clr = 1;
    @(negedge clk);
    model_clr = 0;
  endtask

  task automatic judge(int lst, int dly, int mid_start);
    int fail_at;
    int exp_err;
    fail_at = -1;
    for (int i = 0; i <= lst; i++) if (fail_at < 0 && need[i] > RMAX) fail_at = i;
    exp_err = (fail_at >= 0) ? 1 : ((dly >= TOUT) ? 2 : 0);
    // R6 / R8 / R9 error outcome
    chk(fail_at >= 0 ? "R6 err code" : (exp_err == 2 ? "R9 err code" : "R8 err code"),
        int'(err_code), exp_err);
    for (int i = 0; i < NB; i++) begin
      int et, er;
      if (i > lst || (fail_at >= 0 && i > fail_at)) begin et = 0; er = 0; end
      else if (need[i] > RMAX) begin et = RMAX; er = RMAX + 1; end
      else begin et = need[i]; er = need[i] + 1; end
      chk(need[i] == 0 ? "R4 triggers" : "R5 triggers", trg[i], et);
      chk("R3 reads", rds[i], er);
    end
    chk("R7 halt count", halt_cnt, fail_at >= 0 ? 0 : 1);
    chk("R7 no req after halt", late_req, 0);
    chk("R3 order", ord_viol, 0);
    chk("R11 hold", hold_viol, 0);
    if (mid_start != 0) chk("R2 single done", done_cnt, 1);
  endtask

  task automatic run(int lst, int dly, int mid_start);
    bit ok;
    prep(lst, dly);
    start = 1;
    @(negedge clk);
    start = 0;
    chk("R2 busy after start", int'(busy), 1);
    if (mid_start != 0) begin
      repeat (4) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    wait_done(ok);
    if (ok) begin
      chk("R10 busy low at done", int'(busy), 0);
      @(negedge clk);
      chk("R10 done one cycle", int'(done), 0);
      repeat (3) @(negedge clk);
      judge(lst, dly, mid_start);
      chk("R10 err held", int'(err), int'(err_code != 2'd0));
    end
  endtask

  initial begin
    bit ok;
    for (int i = 0; i < NB; i++) need[i] = 0;
    dly_cfg = 0; sc = 0; dcnt = 0; rsp_valid = 0; rsp_en = 0;
    req_ready = 0; cmd_ready = 0; poc = RUNST;
    model_clr = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 req_valid", int'(req_valid), 0);
    chk("R1 cmd_valid", int'(cmd_valid), 0);
    rst_n = 1;
    model_clr = 0;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", int'(busy) + int'(req_valid) + int'(cmd_valid), 0);

    // exhaustive need patterns, all buffers used
    for (int p = 0; p < 625; p++) begin
      int v = p;
      for (int b = 0; b < NB; b++) begin need[b] = v % 5; v = v / 5; end
      run(NB - 1, 1, (p % 37 == 0) ? 1 : 0);
    end
    // last index sweep
    for (int l = 0; l < NB; l++)
      for (int p = 0; p < 16; p++) begin
        for (int b = 0; b < NB; b++) need[b] = (p >> b) & 1 ? 2 : 0;
        need[NB-1] = (p == 15) ? 4 : need[NB-1];
        run(l, 2, 0);
      end
    // halt delay sweep around the timeout
    for (int b = 0; b < NB; b++) need[b] = 1;
    for (int d = 0; d <= TOUT + 2; d++) run(NB - 1, d, 0);

    // start coinciding with the done pulse (R2)
    for (int b = 0; b < NB; b++) need[b] = b % 3;
    prep(NB - 1, 0);
    start = 1;
    @(negedge clk);
    start = 0;
    wait_done(ok);
    if (ok) begin
      for (int b = 0; b < NB; b++) need[b] = 0;
      start = 1;
      @(negedge clk);
      start = 0;
      chk("R2 start in done cycle", int'(busy), 1);
      wait_done(ok);
      if (ok) chk("R2 second run ok", int'(err_code), 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule